// File: doc/BRIEF.md
# Fixed-Direction GPIO Port with Edge Interrupts

The block is an eight-line general-purpose port attached to a simple byte-wide register bus. It has a 3-bit address, a read strobe, a write strobe and 8-bit write and read data. Lines 0 to 3 are fixed outputs driven from a data latch. Lines 4 to 7 are fixed inputs. Each input passes through a two-stage synchronizer before anything else uses it.

Each input can raise an edge-triggered event. A packed trigger byte gives every input a 2-bit field that selects which edges count. Qualifying edges set pending bits, and software clears them by writing ones. One active-high interrupt line reports to the host whenever any pending bit is set.

There are no explicit states. The pending latch for each input has two named conditions:
- IDLE: the bit is clear. IDLE goes to PENDING on a qualifying edge.
- PENDING: the bit is set. PENDING goes back to IDLE on a write of one to that bit, unless a qualifying edge arrives in the same cycle.

Top module: `pio_edge_port`

## Requirements
- R1: The registers sit at byte offsets 0 (direction), 1 (data), 3 (trigger) and 4 (pending). Offset 2 and offsets 5 to 7 read as 0x00, and writes to them change no register.
- R2: The direction register always reads 0x0F, where a one marks an output. Writes to it have no effect.
- R3: A write to offset 1 loads bits 3:0 into the output latches, which drive `pin_out` from the next clock edge. Bits 7:4 of that write are ignored. The outputs are low after reset.
- R4: A read of offset 1 returns the output latches in bits 3:0 and the synchronized levels of `pin_in[3:0]` in bits 7:4. An input change becomes visible two clock edges after it is applied.
- R5: Input n uses bits [2n+1:2n] of the trigger register. Bit 2n enables falling edges and bit 2n+1 enables rising edges. So 00 is masked, 01 is falling, 10 is rising and 11 is both. The register reads back as written.
- R6: Bit n of the pending register sets on a qualifying edge of input n, three clock edges after the pin changes. Bits 7:4 of the pending register always read zero.
- R7: Writing a one to pending bit n clears it. Zero bits in the write leave their bits unchanged.
- R8: When a qualifying edge and a clear of the same pending bit fall in one cycle, the bit stays set.
- R9: `irq` is high exactly when at least one pending bit is set.
- R10: After reset, the trigger register and the pending register are 0x00 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register byte offset |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid while it is high |
| bus_wr | input | 1 | Write strobe; the write takes effect at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; zero when no read is active |
| pin_in | input | 4 | Asynchronous input lines (port lines 4 to 7) |
| pin_out | output | 4 | Output lines (port lines 0 to 3) |
| irq | output | 1 | Interrupt request, active high |

## Verification
The edge logic is driven with all four inputs switched together under three uniform trigger settings: all rising, all falling and both. Each setting is tried with rising and with falling transitions, which shows whether rising and falling detection are swapped or leak into each other. Alternating pin patterns under a mixed trigger byte give every input a different field, which exposes wrong field positions or a wrong bit order inside a field. Directed sequences cover partial write-one-to-clear, a clear that coincides with a new edge, and the read-back of ignored register bits.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int unsigned REG_AW = 3;

    localparam logic [REG_AW-1:0] OFS_DIR  = 3'd0;
    localparam logic [REG_AW-1:0] OFS_DATA = 3'd1;
    localparam logic [REG_AW-1:0] OFS_TRIG = 3'd3;
    localparam logic [REG_AW-1:0] OFS_PEND = 3'd4;

    // Per-input trigger field: bit 0 = falling, bit 1 = rising
    typedef enum logic [1:0] {
        TRIG_OFF  = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_BOTH = 2'b11
    } trig_e;
endpackage

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
    parameter int unsigned N_IN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] pin_in,
    output logic [N_IN-1:0] level,
    output logic [N_IN-1:0] rise,
    output logic [N_IN-1:0] fall
);
    for (genvar g = 0; g < N_IN; g++) begin : g_line
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_in[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign level[g] = sync_q;
        assign rise[g]  = sync_q & ~prev_q;
        assign fall[g]  = ~sync_q & prev_q;

        assert_edge_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(rise[g] && fall[g]));
    end
endmodule

// File: rtl/pio_edge_qual.sv
module pio_edge_qual
    import pio_pkg::*;
#(
    parameter int unsigned N_IN = 4
) (
    input  logic [2*N_IN-1:0] trig_cfg,
    input  logic [N_IN-1:0]   rise,
    input  logic [N_IN-1:0]   fall,
    output logic [N_IN-1:0]   evt
);
    always_comb begin
        for (int n = 0; n < N_IN; n++) begin
            unique case (trig_e'(trig_cfg[2*n +: 2]))
                TRIG_OFF:  evt[n] = 1'b0;
                TRIG_FALL: evt[n] = fall[n];
                TRIG_RISE: evt[n] = rise[n];
                TRIG_BOTH: evt[n] = rise[n] | fall[n];
                default:   evt[n] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pio_pend_latch.sv
module pio_pend_latch #(
    parameter int unsigned N_IN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] evt,
    input  logic [N_IN-1:0] clr,
    output logic [N_IN-1:0] pend
);
    logic [N_IN-1:0] pend_q;

    // IDLE -> PENDING on evt; PENDING -> IDLE on clr unless evt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | evt;
    end

    assign pend = pend_q;

    for (genvar g = 0; g < N_IN; g++) begin : g_chk
        assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !evt[g]) |=> !pend[g]);
        assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |=> pend[g]);
        assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[g] && !evt[g]) |=> $stable(pend[g]));
    end
endmodule

// File: rtl/pio_edge_port.sv
module pio_edge_port
    import pio_pkg::*;
#(
    parameter int unsigned N_OUT = 4,
    parameter int unsigned N_IN  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [N_IN-1:0]   pin_in,
    output logic [N_OUT-1:0]  pin_out,
    output logic              irq
);
    localparam int unsigned DATA_W = N_OUT + N_IN;
    localparam int unsigned TRIG_W = 2 * N_IN;
    localparam logic [DATA_W-1:0] DIR_FIXED = {{N_IN{1'b0}}, {N_OUT{1'b1}}};

    logic [N_OUT-1:0]  out_q;
    logic [TRIG_W-1:0] trig_q;
    logic [N_IN-1:0]   in_level, in_rise, in_fall, evt, clr, pend;
    logic              wr_data, wr_trig, wr_pend;

    assign wr_data = bus_wr && (bus_addr == OFS_DATA);
    assign wr_trig = bus_wr && (bus_addr == OFS_TRIG);
    assign wr_pend = bus_wr && (bus_addr == OFS_PEND);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            trig_q <= '0;
        end else begin
            if (wr_data) out_q  <= bus_wdata[N_OUT-1:0];
            if (wr_trig) trig_q <= bus_wdata[TRIG_W-1:0];
        end
    end

    assign clr = wr_pend ? bus_wdata[N_IN-1:0] : '0;

    pio_in_sync #(.N_IN(N_IN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .level  (in_level),
        .rise   (in_rise),
        .fall   (in_fall)
    );

    pio_edge_qual #(.N_IN(N_IN)) u_qual (
        .trig_cfg (trig_q),
        .rise     (in_rise),
        .fall     (in_fall),
        .evt      (evt)
    );

    pio_pend_latch #(.N_IN(N_IN)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .clr   (clr),
        .pend  (pend)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                OFS_DIR:  bus_rdata = DIR_FIXED;
                OFS_DATA: bus_rdata = {in_level, out_q};
                OFS_TRIG: bus_rdata = trig_q;
                OFS_PEND: bus_rdata = {{(DATA_W-N_IN){1'b0}}, pend};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = out_q;
    assign irq     = |pend;

    assert_out_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> pin_out == $past(bus_wdata[N_OUT-1:0]));
    assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> $stable(pin_out));
    assert_trig_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_trig |=> $stable(trig_q));
    assert_pend_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_PEND) |-> bus_rdata[7:N_IN] == '0);
    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|evt));
    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_pend));
endmodule

// File: tb/test_pio_edge_port.sv
module test_pio_edge_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] pin_in = '0;
    logic [3:0] pin_out;
    logic       irq;

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pio_edge_port i_pio_edge_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
    );

    // {trigger byte, start pins, end pins, expected pending}  (R5, R6)
    localparam logic [19:0] VEC [0:7] = '{
        {8'hAA, 4'h0, 4'hF, 4'hF},  // all rising, rising edges
        {8'hAA, 4'hF, 4'h0, 4'h0},  // all rising, falling edges
        {8'h55, 4'hF, 4'h0, 4'hF},  // all falling, falling edges
        {8'h55, 4'h0, 4'hF, 4'h0},  // all falling, rising edges
        {8'hFF, 4'h5, 4'hA, 4'hF},  // both edges
        {8'h00, 4'h0, 4'hF, 4'h0},  // masked
        {8'h1B, 4'h5, 4'hA, 4'h7},  // mixed fields
        {8'h1B, 4'hA, 4'h5, 4'h1}   // mixed fields, reversed
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R10, R2, R3)
        bus_read(3'd0, rd); check("R2 reset dir", rd, 8'h0F);
        bus_read(3'd1, rd); check("R3 reset data", rd, 8'h00);
        bus_read(3'd3, rd); check("R10 reset trig", rd, 8'h00);
        bus_read(3'd4, rd); check("R10 reset pend", rd, 8'h00);
        check("R10 reset irq", {7'd0, irq}, 8'h00);
        check("R3 reset pin_out", {4'd0, pin_out}, 8'h00);

        // Vector table: edge qualification
        for (int v = 0; v < 8; v++) begin
            bus_write(3'd3, 8'h00);
            @(negedge clk) pin_in = VEC[v][11:8];
            settle();
            bus_write(3'd4, 8'hFF);
            bus_write(3'd3, VEC[v][19:12]);
            @(negedge clk) pin_in = VEC[v][7:4];
            settle();
            bus_read(3'd4, rd);
            check($sformatf("R5/R6 vector %0d pend", v), rd, {4'h0, VEC[v][3:0]});
            check($sformatf("R9 vector %0d irq", v), {7'd0, irq}, {7'd0, |VEC[v][3:0]});
        end

        // Partial write-one-to-clear (R7, R9): pending is 0x1 from last vector
        bus_write(3'd3, 8'hAA);
        @(negedge clk) pin_in = 4'h0;
        settle();
        @(negedge clk) pin_in = 4'hF;
        settle();
        bus_read(3'd4, rd); check("R6 all rising set", rd, 8'h0F);
        bus_write(3'd4, 8'hF5);
        bus_read(3'd4, rd); check("R7 partial clear", rd, 8'h0A);
        check("R9 irq still high", {7'd0, irq}, 8'h01);
        bus_write(3'd4, 8'h0A);
        bus_read(3'd4, rd); check("R7 full clear", rd, 8'h00);
        check("R9 irq low", {7'd0, irq}, 8'h00);

        // Edge coinciding with a clear (R8)
        bus_write(3'd3, 8'h03);
        @(negedge clk) pin_in = 4'h0;
        settle();
        bus_write(3'd4, 8'hFF);
        @(negedge clk) pin_in = 4'h1;
        settle();
        bus_read(3'd4, rd); check("R8 precondition", rd, 8'h01);
        @(negedge clk) pin_in = 4'h0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = 3'd4; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(negedge clk) bus_wr = 1'b0;
        bus_read(3'd4, rd); check("R8 edge beats clear", rd, 8'h01);
        bus_write(3'd4, 8'h01);
        bus_read(3'd4, rd); check("R7 clear after collision", rd, 8'h00);

        // Data register (R3, R4)
        bus_write(3'd1, 8'hA5);
        check("R3 pin_out load", {4'd0, pin_out}, 8'h05);
        @(negedge clk) pin_in = 4'hC;
        @(negedge clk);
        bus_read(3'd1, rd); check("R4 data readback", rd, 8'hC5);

        // Direction writes ignored (R2), unused offsets (R1)
        bus_write(3'd0, 8'hF0);
        bus_read(3'd0, rd); check("R2 dir write ignored", rd, 8'h0F);
        bus_write(3'd3, 8'h5A);
        bus_write(3'd2, 8'hFF);
        bus_write(3'd7, 8'hFF);
        bus_read(3'd2, rd); check("R1 offset 2 reads zero", rd, 8'h00);
        bus_read(3'd6, rd); check("R1 offset 6 reads zero", rd, 8'h00);
        bus_read(3'd3, rd); check("R1 trig untouched", rd, 8'h5A);
        bus_read(3'd1, rd); check("R1 data untouched", rd, 8'hC5);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule